// File: doc/BRIEF.md
# Indexed Threshold Register Write Port

This block gives a byte-wide register bus indirect write access to a small bank of 24-bit internal registers. Three consecutive byte addresses hold a staged 24-bit value. An index register at the address just below them names the internal target in its low seven bits. Its top bit is the commit command. A commit needs two writes to the index register. The first write, with the top bit clear, selects the target and arms the block. The second write, with the top bit set, copies the staged value into the target that this second write names.

The target bank is driven onto a flat output bus for downstream logic. One target, the jitter loss-of-lock threshold, is also brought out as its own output. The bus protocol front end is outside the block, which sees only a write strobe, an address and a data byte, plus a combinational read port.

A two-state controller sequences the commit:
- **IDLE**: nothing is armed.
  - A select write (bit 7 = 0) takes it to **ARMED** (transition *select*).
  - A commit write (bit 7 = 1) in IDLE is refused, and the state stays IDLE (transition *stray commit*).
- **ARMED**:
  - Another select write re-selects and the state stays ARMED (transition *reselect*).
  - A commit write applies the staged value and returns to IDLE (transition *apply*).
  - Staging-byte writes and other traffic leave the state as it is.

Top module: `idxwin_top`

## Requirements
- R1: After reset, target 4 (the threshold) holds A03FB9h, and every other target, the three staging bytes and the index field are 0. The controller starts in IDLE.
- R2: A write to address 107, 108 or 109 loads that staging byte, and reading the same address returns it.
- R3: A commit stores the staged bytes as one value: byte 107 in bits [23:16], byte 108 in bits [15:8] and byte 109 in bits [7:0].
- R4: A write to address 106 with bit 7 = 0 stores bits [6:0] as the index, moves the controller to ARMED, and changes no target.
- R5: A write to address 106 with bit 7 = 1 while ARMED loads the staged value into target bits [6:0] at that clock edge, and the controller returns to IDLE.
- R6: A write to address 106 with bit 7 = 1 while IDLE changes no target.
- R7: A commit whose index differs from the index latched by the earlier select write updates the target carried in the commit write.
- R8: Reading address 106 returns bit 7 = 0 and, in bits [6:0], the last index written.
- R9: The staging bytes keep their contents after a commit, so one staged value can be committed to several targets.
- R10: A commit that names an index of TGT_COUNT (8) or more changes no target, and the controller returns to IDLE.
- R11: The `threshold` output always equals target 4.
- R12: A write with `wr_en` low, or a write to any address outside 106 to 109, changes no target, no staging byte and no index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| tgt_flat | output | 192 | All targets; target n occupies bits [24n+23:24n] |
| threshold | output | 24 | Target 4, the loss-of-lock threshold |

## Verification
Every write takes effect at the clock edge that samples it. A staging byte, the index field, the controller state or a target therefore changes one edge after the write is driven. Read data follows `rd_addr` in the same cycle.

The bench drives inputs just after the falling edge and checks on the falling edge that follows. At that point exactly one rising edge has passed. On every clock it compares all targets, the threshold and the read port against a behavioural model that has been updated at that rising edge. Directed checks made right after each write task cover each requirement by name.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
    localparam int DATA_W = 8;
    localparam int VAL_W  = 24;
    localparam int NBYTES = VAL_W / DATA_W;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } win_state_t;
endpackage

// File: rtl/idxwin_stage.sv
module idxwin_stage
    import idxwin_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 106
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VAL_W-1:0]  stage_val
);
    // lane 0 sits at BASE+1 and forms the most significant byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + 1 + b);
        localparam int                LSB       = (NBYTES - 1 - b) * DATA_W;
        logic [DATA_W-1:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == LANE_ADDR)) begin
                byte_q <= wr_data;
            end
        end

        assign stage_val[LSB +: DATA_W] = byte_q;
    end
endmodule

// File: rtl/idxwin_ctrl.sv
module idxwin_ctrl
    import idxwin_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 106,
    parameter int IDX_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]  idx_q,
    output logic              armed,
    output logic              commit_vld,
    output logic [IDX_W-1:0]  commit_idx
);
    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);

    win_state_t state_q, state_d;
    logic       idx_wr;
    logic       cmd_bit;

    assign idx_wr  = wr_en && (wr_addr == IDX_ADDR);
    assign cmd_bit = wr_data[DATA_W-1];

    // state register and index field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (idx_wr) begin
                idx_q <= wr_data[IDX_W-1:0];
            end
        end
    end

    // next state: select, reselect, apply, stray commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (idx_wr && !cmd_bit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (idx_wr && cmd_bit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_vld = 1'b0;
        commit_idx = wr_data[IDX_W-1:0];
        armed      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                armed = 1'b0;
            end
            ST_ARMED: begin
                armed      = 1'b1;
                commit_vld = idx_wr && cmd_bit;
            end
            default: begin
                armed = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/idxwin_bank.sv
module idxwin_bank
    import idxwin_pkg::*;
#(
    parameter int               IDX_W     = 7,
    parameter int               TGT_COUNT = 8,
    parameter int               THR_IDX   = 4,
    parameter logic [VAL_W-1:0] THR_RESET = 24'hA03FB9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_vld,
    input  logic [IDX_W-1:0]           commit_idx,
    input  logic [VAL_W-1:0]           stage_val,
    output logic [TGT_COUNT*VAL_W-1:0] tgt_flat
);
    for (genvar g = 0; g < TGT_COUNT; g++) begin : g_tgt
        localparam logic [VAL_W-1:0] RST_VAL = (g == THR_IDX) ? THR_RESET : '0;
        logic [VAL_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= RST_VAL;
            end else if (commit_vld && (commit_idx == IDX_W'(g))) begin
                val_q <= stage_val;
            end
        end

        assign tgt_flat[g*VAL_W +: VAL_W] = val_q;
    end
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
    import idxwin_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter int               BASE_ADDR = 106,
    parameter int               IDX_W     = 7,
    parameter int               TGT_COUNT = 8,
    parameter int               THR_IDX   = 4,
    parameter logic [23:0]      THR_RESET = 24'hA03FB9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data,
    output logic [TGT_COUNT*24-1:0]    tgt_flat,
    output logic [23:0]                threshold
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(BASE_ADDR + 1);
    localparam logic [ADDR_W-1:0] A_MID = ADDR_W'(BASE_ADDR + 2);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(BASE_ADDR + 3);

    logic [VAL_W-1:0] stage_val;
    logic [IDX_W-1:0] idx_q;
    logic             armed;
    logic             commit_vld;
    logic [IDX_W-1:0] commit_idx;

    idxwin_stage #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stage_val(stage_val)
    );

    idxwin_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .idx_q(idx_q), .armed(armed),
        .commit_vld(commit_vld), .commit_idx(commit_idx)
    );

    idxwin_bank #(.IDX_W(IDX_W), .TGT_COUNT(TGT_COUNT), .THR_IDX(THR_IDX),
                  .THR_RESET(THR_RESET)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit_vld(commit_vld),
        .commit_idx(commit_idx), .stage_val(stage_val), .tgt_flat(tgt_flat)
    );

    assign threshold = tgt_flat[THR_IDX*VAL_W +: VAL_W];

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_IDX)      rd_data = 8'(idx_q);
        else if (rd_addr == A_HI)  rd_data = stage_val[23:16];
        else if (rd_addr == A_MID) rd_data = stage_val[15:8];
        else if (rd_addr == A_LO)  rd_data = stage_val[7:0];
    end
endmodule

// File: rtl/idxwin_chk.sv
module idxwin_chk #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 106,
    parameter int TGT_COUNT = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [7:0]              wr_data,
    input logic [ADDR_W-1:0]       rd_addr,
    input logic [7:0]              rd_data,
    input logic [TGT_COUNT*24-1:0] tgt_flat,
    input logic [23:0]             stage_val,
    input logic                    armed
);
    logic idx_wr;
    logic in_range;
    assign idx_wr   = wr_en && (wr_addr == ADDR_W'(BASE_ADDR));
    assign in_range = int'(wr_data[6:0]) < TGT_COUNT;

    a_r5_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wr_data[7] && armed && in_range) |=>
        (tgt_flat[int'($past(wr_data[6:0]))*24 +: 24] == $past(stage_val)) && !armed);

    a_r6_stray_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wr_data[7] && !armed) |=> $stable(tgt_flat));

    a_r4_select_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && !wr_data[7]) |=> armed && $stable(tgt_flat));

    a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wr_data[7] && armed && !in_range) |=> $stable(tgt_flat) && !armed);

    a_r12_no_index_write: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(tgt_flat));

    a_r8_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(BASE_ADDR)) |-> !rd_data[7]);
endmodule

bind idxwin_top idxwin_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .TGT_COUNT(TGT_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tgt_flat(tgt_flat),
    .stage_val(stage_val), .armed(armed)
);

// File: tb/idxwin_top_tb.sv
module idxwin_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_addr = 8'd106;
    logic [7:0]    rd_data;
    logic [NT*24-1:0] tgt_flat;
    logic [23:0]   threshold;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference
    logic [23:0] m_tgt [NT];
    logic [7:0]  m_stage [3];
    logic [6:0]  m_idx;
    bit          m_armed;

    idxwin_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tgt_flat(tgt_flat), .threshold(threshold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) m_tgt[i] = (i == 4) ? 24'hA03FB9 : 24'h0;
            for (int i = 0; i < 3; i++) m_stage[i] = 8'h0;
            m_idx = '0;
            m_armed = 0;
        end else if (wr_en) begin
            if (wr_addr >= 8'd107 && wr_addr <= 8'd109) begin
                m_stage[wr_addr - 8'd107] = wr_data;
            end else if (wr_addr == 8'd106) begin
                m_idx = wr_data[6:0];
                if (!wr_data[7]) begin
                    m_armed = 1;
                end else if (m_armed) begin
                    if (int'(wr_data[6:0]) < NT)
                        m_tgt[wr_data[6:0]] = {m_stage[0], m_stage[1], m_stage[2]};
                    m_armed = 0;
                end
            end
        end
    end

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'd106) return {1'b0, m_idx};
        if (a >= 8'd107 && a <= 8'd109) return m_stage[a - 8'd107];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NT; i++) chk("R3/R5 target", 32'(tgt_flat[i*24 +: 24]), 32'(m_tgt[i]));
            chk("R11 threshold", 32'(threshold), 32'(m_tgt[4]));
            chk("R2/R8 readback", 32'(rd_data), 32'(m_read(rd_addr)));
        end
    end

    // read address walks 105..110 every cycle
    always @(posedge clk) rd_addr <= (rd_addr >= 8'd110) ? 8'd105 : rd_addr + 8'd1;

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [23:0] tg(input int i);
        return tgt_flat[i*24 +: 24];
    endfunction

    initial begin
        #(CLK_PERIOD*100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 threshold reset", 32'(threshold), 32'hA03FB9);
        chk("R1 target0 reset", 32'(tg(0)), 32'h0);
        chk("R1 target7 reset", 32'(tg(7)), 32'h0);
        rst_n = 1'b1;

        // recommended-style sequence with distinct bytes: R2, R3, R4, R5
        wr(8'd107, 8'h11); wr(8'd108, 8'h22); wr(8'd109, 8'h33);
        wr(8'd106, 8'h04);
        chk("R4 select leaves threshold", 32'(threshold), 32'hA03FB9);
        wr(8'd106, 8'h84);
        chk("R3 byte order / R5 commit", 32'(threshold), 32'h112233);

        // R6 commit while idle is refused; R8 index field readback
        wr(8'd106, 8'h85);
        chk("R6 stray commit", 32'(tg(5)), 32'h0);
        chk("R8 index readback", 32'(m_read(8'd106)), 32'h05);

        // R7 commit index differs from selected index
        wr(8'd106, 8'h02);
        wr(8'd106, 8'h86);
        chk("R7 carried index target", 32'(tg(6)), 32'h112233);
        chk("R7 selected index untouched", 32'(tg(2)), 32'h0);

        // R9 staged bytes survive, commit again to target 1
        wr(8'd106, 8'h01);
        wr(8'd106, 8'h81);
        chk("R9 recommit same value", 32'(tg(1)), 32'h112233);

        // R2 staging write while armed, reselect, commit to 3
        wr(8'd106, 8'h07);
        wr(8'd109, 8'hC4);
        wr(8'd106, 8'h03);
        wr(8'd106, 8'h83);
        chk("R2 staged low byte committed", 32'(tg(3)), 32'h1122C4);
        chk("R2 target7 untouched", 32'(tg(7)), 32'h0);

        // R10 out-of-range index, then check state returned to IDLE
        wr(8'd106, 8'h10);
        wr(8'd106, 8'h90);
        chk("R10 threshold unchanged", 32'(threshold), 32'h112233);
        wr(8'd106, 8'h84);
        chk("R10 back to idle", 32'(threshold), 32'h112233);

        // R12 wr_en low and foreign addresses
        @(negedge clk); #1;
        wr_en = 1'b0; wr_addr = 8'd107; wr_data = 8'hEE;
        @(negedge clk); #1;
        wr(8'd105, 8'h04); wr(8'd110, 8'h84); wr(8'd106, 8'h04);
        @(negedge clk); #1;
        wr_en = 1'b0; wr_addr = 8'd106; wr_data = 8'h84;
        @(negedge clk); #1;
        chk("R12 disabled write ignored", 32'(threshold), 32'h112233);
        chk("R12 stage kept", 32'(m_stage[0]), 32'h11);
        wr(8'd106, 8'h84);
        chk("R12 commit after ignored traffic", 32'(threshold), 32'h1122C4);
        chk("R11 threshold tracks target 4", 32'(threshold), 32'(tg(4)));

        repeat (8) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule